// File: doc/BRIEF.md
# Segmented Parallel Prefix Accumulator

This block merges a whole cacheline of vertex updates in one pass. Each cycle it accepts a fixed number of lanes. Every lane carries an update value, a lane-valid bit and a short tag, which is the low bits of the destination vertex the value belongs to. Lanes that share a destination sit next to each other, so each destination owns a contiguous run of lanes. A log-depth divide-and-conquer prefix network, with one register stage per level, folds each run with one associative, commutative operator. A parameter selects the operator: wrapping integer addition or unsigned minimum. At every node the tags of the two inputs are compared. A tag change, an idle lane or a cut already seen inside the window stops the fold, so no value ever crosses a vertex boundary.

Alongside the line, the vertex scheduler supplies up to a fixed number of result slots. Each slot names a full vertex ID and the lane that holds that vertex's last edge. An output selector picks the folded value at that lane and emits it with the full ID and a valid flag. The latency is fixed and a new line is accepted every cycle. Results are never merged across cycles. That merging is the job of the stage downstream.

The block has no control state machine. All of its state is the pipeline registers.

Top module: `seg_prefix_accum`

## Requirements
- R1: While `rst` is high, and for the first LAT-1 clock edges after its release, every bit of `res_vld` is 0, whatever the inputs carry.
- R2: Latency is fixed at LAT = log2(LANES)+1 clock edges, which is 5 by default. A line sampled at one edge drives its slots' `res_vld` at the LAT-th following edge. Lines are accepted every cycle with no stall, and each line's results are independent of its neighbours.
- R3: With `OP = OP_ADD`, lane i occupies `lane_val[i*DW +: DW]`, `lane_tag[i*TAGW +: TAGW]` and `lane_vld[i]`. Each selected result is the sum, modulo 2^DW, of the values from the first lane of its run through the selected lane.
- R4: With `OP = OP_MIN`, each selected result is the unsigned minimum over the same lanes as in R3.
- R5: A run ends wherever two neighbouring valid lanes carry different tags. No value from one run reaches a result of another run.
- R6: A lane with `lane_vld` low contributes nothing and breaks its run. The valid lane after it starts a new run even when its tag is equal.
- R7: Two runs that are not neighbours may carry the same tag and still stay separate. Only neighbouring runs must differ in tag.
- R8: Slot k selects lane `sched_last[k*TAGW +: TAGW]` (a lane index). The result is the fold of that lane's run from its first lane up to the selected lane, so a lane inside a run yields the partial prefix.
- R9: Slot k occupies `res_id[k*VIDW +: VIDW]` and `res_val[k*DW +: DW]`. A scheduled slot returns `sched_id` unchanged with `res_vld[k]` high. An unscheduled slot returns `res_vld[k]` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_vld | input | LANES | Per-lane valid |
| lane_tag | input | LANES*TAGW | Per-lane low bits of the destination vertex ID |
| lane_val | input | LANES*DW | Per-lane update value |
| sched_vld | input | OUTS | Slot is scheduled this line |
| sched_id | input | OUTS*VIDW | Full destination vertex ID per slot |
| sched_last | input | OUTS*TAGW | Lane index of the vertex's last edge per slot |
| res_vld | output | OUTS | Result valid per slot |
| res_id | output | OUTS*VIDW | Full vertex ID per slot |
| res_val | output | OUTS*DW | Folded value per slot |

## Verification
The riskiest case is a single line that holds a tag-change cut, an idle-lane cut and a partial-run selection at the same time. All three go through the same network nodes within one cycle. The bench sweeps every one of the 2^15 boundary patterns among the 16 lanes, one line per cycle. Some lines put idle lanes inside runs, and some alternate only two tags, so that distant runs share a tag. Each slot's value, ID and valid are compared, for both operators, with a backward walk computed in the bench.

// File: rtl/seg_accum_pkg.sv
package seg_accum_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MIN = 1'b1
    } comb_op_e;

    // lane that feeds lane `lane` at prefix level `lvl`
    function automatic int partner_lane(int lane, int lvl);
        return ((lane >> lvl) << lvl) - 1;
    endfunction
endpackage

// File: rtl/seg_prefix_level.sv
module seg_prefix_level
    import seg_accum_pkg::*;
#(
    parameter int       LANES = 16,
    parameter int       DW    = 32,
    parameter int       TAGW  = 4,
    parameter int       LVL   = 0,
    parameter comb_op_e OP    = OP_ADD
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES-1:0]      in_vld,
    input  logic [LANES-1:0]      in_cut,
    input  logic [LANES*TAGW-1:0] in_tag,
    input  logic [LANES*DW-1:0]   in_val,
    output logic [LANES-1:0]      out_vld,
    output logic [LANES-1:0]      out_cut,
    output logic [LANES*TAGW-1:0] out_tag,
    output logic [LANES*DW-1:0]   out_val
);
    logic [LANES-1:0]    nxt_cut;
    logic [LANES*DW-1:0] nxt_val;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (((i >> LVL) & 1) == 1) begin : g_node
            localparam int J = partner_lane(i, LVL);
            logic          brk;
            logic [DW-1:0] lo;
            logic [DW-1:0] hi;
            logic [DW-1:0] merged;

            assign lo  = in_val[J*DW +: DW];
            assign hi  = in_val[i*DW +: DW];
            assign brk = in_cut[i] | ~in_vld[J]
                       | (in_tag[J*TAGW +: TAGW] != in_tag[i*TAGW +: TAGW]);

            if (OP == OP_MIN) begin : g_min
                assign merged = (lo < hi) ? lo : hi;
            end else begin : g_add
                assign merged = lo + hi;
            end

            assign nxt_val[i*DW +: DW] = brk ? hi : merged;
            assign nxt_cut[i]          = brk | in_cut[J];

            // tag change between the two inputs: right value passes untouched
            p_tag_break_r5: assert property (@(posedge clk) disable iff (rst)
                (in_vld[i] && in_vld[J] &&
                 (in_tag[J*TAGW +: TAGW] != in_tag[i*TAGW +: TAGW]))
                |=> (out_val[i*DW +: DW] == $past(in_val[i*DW +: DW])));

            // idle partner contributes nothing
            p_idle_partner_r6: assert property (@(posedge clk) disable iff (rst)
                (in_vld[i] && !in_vld[J])
                |=> (out_val[i*DW +: DW] == $past(in_val[i*DW +: DW])));
        end else begin : g_pass
            assign nxt_val[i*DW +: DW] = in_val[i*DW +: DW];
            assign nxt_cut[i]          = in_cut[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= '0;
            out_cut <= '1;
            out_tag <= '0;
            out_val <= '0;
        end else begin
            out_vld <= in_vld;
            out_cut <= nxt_cut;
            out_tag <= in_tag;
            out_val <= nxt_val;
        end
    end
endmodule

// File: rtl/seg_prefix_select.sv
module seg_prefix_select #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int VIDW  = 32,
    parameter int OUTS  = 8,
    parameter int TAGW  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES*DW-1:0]   lane_val,
    input  logic [OUTS-1:0]       sched_vld,
    input  logic [OUTS*VIDW-1:0]  sched_id,
    input  logic [OUTS*TAGW-1:0]  sched_last,
    output logic [OUTS-1:0]       res_vld,
    output logic [OUTS*VIDW-1:0]  res_id,
    output logic [OUTS*DW-1:0]    res_val
);
    logic [DW-1:0] lane_arr [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_unpack
        assign lane_arr[i] = lane_val[i*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld <= '0;
            res_id  <= '0;
            res_val <= '0;
        end else begin
            res_vld <= sched_vld;
            res_id  <= sched_id;
            for (int k = 0; k < OUTS; k++) begin
                res_val[k*DW +: DW] <= lane_arr[sched_last[k*TAGW +: TAGW]];
            end
        end
    end

    for (genvar k = 0; k < OUTS; k++) begin : g_chk
        p_idle_slot_r9: assert property (@(posedge clk) disable iff (rst)
            !sched_vld[k] |=> !res_vld[k]);
    end
endmodule

// File: rtl/seg_prefix_accum.sv
module seg_prefix_accum
    import seg_accum_pkg::*;
#(
    parameter int       LANES = 16,
    parameter int       DW    = 32,
    parameter int       VIDW  = 32,
    parameter int       OUTS  = 8,
    parameter comb_op_e OP    = OP_ADD
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [LANES-1:0]                    lane_vld,
    input  logic [LANES*$clog2(LANES)-1:0]      lane_tag,
    input  logic [LANES*DW-1:0]                 lane_val,
    input  logic [OUTS-1:0]                     sched_vld,
    input  logic [OUTS*VIDW-1:0]                sched_id,
    input  logic [OUTS*$clog2(LANES)-1:0]       sched_last,
    output logic [OUTS-1:0]                     res_vld,
    output logic [OUTS*VIDW-1:0]                res_id,
    output logic [OUTS*DW-1:0]                  res_val
);
    localparam int TAGW   = $clog2(LANES);
    localparam int LEVELS = $clog2(LANES);
    localparam int LAT    = LEVELS + 1;
    localparam int WARMW  = $clog2(LAT + 1);

    logic [LEVELS:0][LANES-1:0]      st_vld;
    logic [LEVELS:0][LANES-1:0]      st_cut;
    logic [LEVELS:0][LANES*TAGW-1:0] st_tag;
    logic [LEVELS:0][LANES*DW-1:0]   st_val;

    assign st_vld[0] = lane_vld;
    assign st_cut[0] = ~lane_vld;
    assign st_tag[0] = lane_tag;
    assign st_val[0] = lane_val;

    for (genvar s = 0; s < LEVELS; s++) begin : g_level
        seg_prefix_level #(
            .LANES(LANES), .DW(DW), .TAGW(TAGW), .LVL(s), .OP(OP)
        ) u_level (
            .clk    (clk),
            .rst    (rst),
            .in_vld (st_vld[s]),
            .in_cut (st_cut[s]),
            .in_tag (st_tag[s]),
            .in_val (st_val[s]),
            .out_vld(st_vld[s+1]),
            .out_cut(st_cut[s+1]),
            .out_tag(st_tag[s+1]),
            .out_val(st_val[s+1])
        );
    end

    // schedule rides beside the network, one register per level
    logic [LEVELS-1:0][OUTS-1:0]      sd_vld;
    logic [LEVELS-1:0][OUTS*VIDW-1:0] sd_id;
    logic [LEVELS-1:0][OUTS*TAGW-1:0] sd_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_vld  <= '0;
            sd_id   <= '0;
            sd_last <= '0;
        end else begin
            sd_vld[0]  <= sched_vld;
            sd_id[0]   <= sched_id;
            sd_last[0] <= sched_last;
            for (int s = 1; s < LEVELS; s++) begin
                sd_vld[s]  <= sd_vld[s-1];
                sd_id[s]   <= sd_id[s-1];
                sd_last[s] <= sd_last[s-1];
            end
        end
    end

    seg_prefix_select #(
        .LANES(LANES), .DW(DW), .VIDW(VIDW), .OUTS(OUTS), .TAGW(TAGW)
    ) u_select (
        .clk       (clk),
        .rst       (rst),
        .lane_val  (st_val[LEVELS]),
        .sched_vld (sd_vld[LEVELS-1]),
        .sched_id  (sd_id[LEVELS-1]),
        .sched_last(sd_last[LEVELS-1]),
        .res_vld   (res_vld),
        .res_id    (res_id),
        .res_val   (res_val)
    );

    // edges since reset release, saturating; guards history-based checks
    logic [WARMW-1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= '0;
        end else if (warm != WARMW'(LAT)) begin
            warm <= warm + 1'b1;
        end
    end

    for (genvar k = 0; k < OUTS; k++) begin : g_chk
        p_fixed_latency_r2: assert property (@(posedge clk) disable iff (rst)
            (warm == WARMW'(LAT)) |-> (res_vld[k] == $past(sched_vld[k], LAT)));
        p_id_carried_r9: assert property (@(posedge clk) disable iff (rst)
            ((warm == WARMW'(LAT)) && res_vld[k])
            |-> (res_id[k*VIDW +: VIDW] == $past(sched_id[k*VIDW +: VIDW], LAT)));
    end
endmodule

// File: tb/test_seg_prefix_accum.sv
module test_seg_prefix_accum;
    import seg_accum_pkg::*;

    localparam int LANES  = 16;
    localparam int DW     = 32;
    localparam int VIDW   = 32;
    localparam int OUTS   = 8;
    localparam int TAGW   = 4;
    localparam int LAT    = 5;
    localparam int NLINES = 32768;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [LANES-1:0]      lane_vld   = '0;
    logic [LANES*TAGW-1:0] lane_tag   = '0;
    logic [LANES*DW-1:0]   lane_val   = '0;
    logic [OUTS-1:0]       sched_vld  = '0;
    logic [OUTS*VIDW-1:0]  sched_id   = '0;
    logic [OUTS*TAGW-1:0]  sched_last = '0;

    logic [OUTS-1:0]      a_vld, m_vld;
    logic [OUTS*VIDW-1:0] a_id,  m_id;
    logic [OUTS*DW-1:0]   a_val, m_val;

    always #4 clk = ~clk;

    seg_prefix_accum #(.LANES(LANES), .DW(DW), .VIDW(VIDW), .OUTS(OUTS), .OP(OP_ADD))
    i_seg_prefix_accum (
        .clk(clk), .rst(rst), .lane_vld(lane_vld), .lane_tag(lane_tag),
        .lane_val(lane_val), .sched_vld(sched_vld), .sched_id(sched_id),
        .sched_last(sched_last), .res_vld(a_vld), .res_id(a_id), .res_val(a_val)
    );

    seg_prefix_accum #(.LANES(LANES), .DW(DW), .VIDW(VIDW), .OUTS(OUTS), .OP(OP_MIN))
    i_seg_prefix_accum_min (
        .clk(clk), .rst(rst), .lane_vld(lane_vld), .lane_tag(lane_tag),
        .lane_val(lane_val), .sched_vld(sched_vld), .sched_id(sched_id),
        .sched_last(sched_last), .res_vld(m_vld), .res_id(m_id), .res_val(m_val)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] rnd = 32'h2545_f491;

    logic [OUTS-1:0] e_vld [8];
    logic [31:0]     e_id  [8][OUTS];
    logic [31:0]     e_add [8][OUTS];
    logic [31:0]     e_min [8][OUTS];
    string           e_lbl [8][OUTS];

    task automatic next_rnd();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 17);
        rnd = rnd ^ (rnd << 5);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_line(int n);
        logic [LANES-1:0] vl;
        logic [3:0]       tg [LANES];
        logic [31:0]      vv [LANES];
        logic [3:0]       base;
        int               s;
        bit               alt, holes;
        int               m;
        m = n % 8;
        next_rnd();
        base  = rnd[3:0];
        alt   = (n % 3 == 1);
        holes = (n % 4 == 2);
        s = 0;
        for (int i = 0; i < LANES; i++) begin
            if (i > 0 && n[i-1]) s++;
            tg[i] = alt ? (base + (s[0] ? 4'd7 : 4'd0)) : (base + 4'(s));
            next_rnd();
            vv[i] = rnd;
            vl[i] = holes ? (rnd[31:29] != 3'd0) : 1'b1;
            lane_val[i*DW +: DW]     = vv[i];
            lane_tag[i*TAGW +: TAGW] = tg[i];
        end
        lane_vld = vl;
        for (int k = 0; k < OUTS; k++) begin
            int last;
            int j;
            logic [31:0] acc_a, acc_m;
            bit sv;
            next_rnd();
            last = 2 * k + int'(rnd[0]);
            sv   = vl[last] && (rnd[2:1] != 2'd0);
            sched_vld[k]                = sv;
            sched_id[k*VIDW +: VIDW]    = {rnd[31:4], tg[last]};
            sched_last[k*TAGW +: TAGW]  = 4'(last);
            acc_a = vv[last];
            acc_m = vv[last];
            j = last;
            while (j > 0 && vl[j] && vl[j-1] && tg[j-1] == tg[j]) begin
                j--;
                acc_a = acc_a + vv[j];
                if (vv[j] < acc_m) acc_m = vv[j];
            end
            e_vld[m][k] = sv;
            e_id[m][k]  = {rnd[31:4], tg[last]};
            e_add[m][k] = acc_a;
            e_min[m][k] = acc_m;
            if (alt)                                            e_lbl[m][k] = "R7";
            else if (holes)                                     e_lbl[m][k] = "R6";
            else if (last == LANES-1 || tg[last+1] != tg[last]) e_lbl[m][k] = "R5";
            else                                                e_lbl[m][k] = "R8";
        end
    endtask

    task automatic check_line(int n);
        int m;
        m = n % 8;
        for (int k = 0; k < OUTS; k++) begin
            if (e_vld[m][k]) begin
                chk("R2 add valid", 32'(a_vld[k]), 32'd1);
                chk("R2 min valid", 32'(m_vld[k]), 32'd1);
                chk("R9 add id", a_id[k*VIDW +: VIDW], e_id[m][k]);
                chk("R9 min id", m_id[k*VIDW +: VIDW], e_id[m][k]);
                chk({"R3/", e_lbl[m][k]}, a_val[k*DW +: DW], e_add[m][k]);
                chk({"R4/", e_lbl[m][k]}, m_val[k*DW +: DW], e_min[m][k]);
            end else begin
                chk("R9 add idle", 32'(a_vld[k]), 32'd0);
                chk("R9 min idle", 32'(m_vld[k]), 32'd0);
            end
        end
    endtask

    initial begin
        lane_vld  = '1;
        sched_vld = '1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R1 in reset add", 32'(a_vld), 32'd0);
            chk("R1 in reset min", 32'(m_vld), 32'd0);
        end
        for (int c = 0; c < NLINES + LAT; c++) begin
            @(negedge clk);
            rst = 1'b0;
            if (c >= LAT) begin
                check_line(c - LAT);
            end else begin
                chk("R1 after release add", 32'(a_vld), 32'd0);
                chk("R1 after release min", 32'(m_vld), 32'd0);
            end
            if (c < NLINES) begin
                drive_line(c);
            end else begin
                lane_vld  = '0;
                sched_vld = '0;
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule